// File: doc/BRIEF.md
# Dual Accumulator Serial Arithmetic Unit

This block keeps two recirculating accumulators. Accumulator A holds the most significant half of a double-length number and accumulator B holds the least significant half. It handles one word time at a time. A word time is WIDTH clock cycles, and during it the operand bits move through the block least significant bit first. One serial operand comes from drum storage and one from the fast registers. A first serial adder (the pre-adder) sums these two operands. A second serial adder, one per accumulator, then adds that sum to the chosen accumulator or subtracts it.

Six function bits, taken at the start pulse, set what one word time does:

- which accumulator is used;
- whether the recirculation of that accumulator is cut, which clears it;
- whether the pre-adder sum is subtracted rather than added;
- whether a unit is added in the least significant place;
- whether both accumulators shift one place left or one place right.

A shift is made by lengthening or shortening the recirculation loop by one place. The two accumulators are coupled across the shift, so a bit can pass from one into the other. While the word runs, the old contents of the selected accumulator are presented serially so they can be stored. When the fast-register address selects register 3, the fast operand is the B accumulator itself.

Top module: `dacc_unit`

## Requirements
- R1: After reset both accumulators read zero and busy_o is low.
- R2: With A selected (op_selb_i=0), no clear and no shift, A becomes A + drum + fast modulo 2^WIDTH and B is unchanged.
- R3: With op_selb_i=1, B becomes B + drum + fast modulo 2^WIDTH and A is unchanged.
- R4: op_clr_i zeroes the selected accumulator before the addition, so it becomes drum + fast.
- R5: op_sub_i makes the selected accumulator become its value minus (drum + fast).
- R6: op_inc_i adds one to the pre-adder sum only when B is selected. With A selected it has no effect.
- R7: op_shl_i alone shifts both accumulators one place left before the add. The old bit WIDTH-1 of B enters bit 0 of A, and 0 enters bit 0 of B.
- R8: op_shr_i alone shifts both accumulators one place right before the add. Bit WIDTH-1 of A keeps its old value (sign), and the old bit 0 of A enters bit WIDTH-1 of B.
- R9: When op_clr_i is set during a left shift, 0 enters bit 0 of A instead of the bit from B.
- R10: With op_shl_i and op_shr_i both set, neither accumulator shifts.
- R11: When fast_addr_i equals 3, the fast operand is the old value of B and fast_bit_i is ignored.
- R12: After a start while idle, busy_o is high for exactly WIDTH cycles. During those cycles store_bit_o gives the old value of the selected accumulator, bit k in cycle k. A start while busy is ignored. Both accumulators hold their values while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a word time when idle; latches the function bits |
| op_selb_i | input | 1 | Select accumulator B instead of A |
| op_clr_i | input | 1 | Clear the selected accumulator before adding; blocks left-shift carry from B into A |
| op_sub_i | input | 1 | Subtract the pre-adder sum instead of adding it |
| op_inc_i | input | 1 | Add one in the least significant place (B selected only) |
| op_shl_i | input | 1 | Shift both accumulators one place left |
| op_shr_i | input | 1 | Shift both accumulators one place right |
| fast_addr_i | input | FADDR_W | Fast-register address; value 3 reads accumulator B |
| drum_bit_i | input | 1 | Serial drum operand, LSB first, one bit per busy cycle |
| fast_bit_i | input | 1 | Serial fast-register operand, LSB first |
| busy_o | output | 1 | High while a word time runs |
| store_bit_o | output | 1 | Serial old contents of the selected accumulator |
| acc_a_o | output | WIDTH | Accumulator A contents, valid while idle |
| acc_b_o | output | WIDTH | Accumulator B contents, valid while idle |

## Verification
The bench aims at the bits that cross word edges. It checks the B-to-A bit on a left shift, with and without the clear bit. A design that took the wrong end of B, or ignored the block, would leave a wrong bit 0 in A. It checks the A-to-B bit and the sign copy on a right shift of a negative A. A late capture here would put an already-overwritten bit into B or lose the sign. Subtraction and the increment are driven to the all-ones wrap, which exposes a carry-in error or an increment wrongly applied to A. It also checks: both shift bits set together, where a design that shifted anyway would corrupt both halves; the self-read of B at address 3; and a second start pulse in the middle of a word, which a faulty sequencer would take as a restart.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2
    } shift_e;

    typedef struct packed {
        logic   sel_b;
        logic   clr;
        logic   sub;
        logic   inc;
        shift_e shift;
    } op_t;

endpackage

// File: rtl/dacc_serial_add.sv
// Bit-serial adder: one carry flip-flop, carry seeded on the first bit.
module dacc_serial_add (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic first_i,
    input  logic cin_i,
    input  logic a_i,
    input  logic b_i,
    output logic sum_o
);
    logic carry_q, carry_d;
    logic c_in;

    always_comb begin
        c_in    = first_i ? cin_i : carry_q;
        sum_o   = a_i ^ b_i ^ c_in;
        carry_d = carry_q;
        if (en_i) begin
            carry_d = (a_i & b_i) | (a_i & c_in) | (b_i & c_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_d;
    end
endmodule

// File: rtl/dacc_lane.sv
// One recirculating accumulator. The loop taps one place earlier (right
// shift) or through one extra flop (left shift) to change its length.
module dacc_lane
    import dacc_pkg::*;
#(
    parameter int unsigned WIDTH = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             first_i,
    input  logic             last_i,
    input  shift_e           shift_i,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic             sub_i,
    input  logic             pre_i,
    input  logic             lin_i,
    input  logic             rin_i,
    output logic             out_o,
    output logic [WIDTH-1:0] val_o
);
    typedef struct packed {
        logic [WIDTH-1:0] acc;
        logic             dly;
    } lane_st_t;

    lane_st_t st_q, st_d;
    logic     loop_bit;
    logic     add_a, add_b, add_cin, add_sum;

    dacc_serial_add i_add (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .first_i (first_i),
        .cin_i   (add_cin),
        .a_i     (add_a),
        .b_i     (add_b),
        .sum_o   (add_sum)
    );

    always_comb begin
        unique case (shift_i)
            SH_LEFT:  loop_bit = first_i ? lin_i : st_q.dly;
            SH_RIGHT: loop_bit = last_i  ? rin_i : st_q.acc[1];
            default:  loop_bit = st_q.acc[0];
        endcase
        add_a   = clr_i ? 1'b0 : loop_bit;
        add_b   = add_i ? (pre_i ^ sub_i) : 1'b0;
        add_cin = add_i & sub_i;

        st_d = st_q;
        if (en_i) begin
            st_d.acc = {add_sum, st_q.acc[WIDTH-1:1]};
            st_d.dly = st_q.acc[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.acc[0];
    assign val_o = st_q.acc;
endmodule

// File: rtl/dacc_unit.sv
module dacc_unit
    import dacc_pkg::*;
#(
    parameter int unsigned WIDTH   = 33,
    parameter int unsigned FADDR_W = 5,
    parameter int unsigned B_ADDR  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               op_selb_i,
    input  logic               op_clr_i,
    input  logic               op_sub_i,
    input  logic               op_inc_i,
    input  logic               op_shl_i,
    input  logic               op_shr_i,
    input  logic [FADDR_W-1:0] fast_addr_i,
    input  logic               drum_bit_i,
    input  logic               fast_bit_i,
    output logic               busy_o,
    output logic               store_bit_o,
    output logic [WIDTH-1:0]   acc_a_o,
    output logic [WIDTH-1:0]   acc_b_o
);
    localparam int unsigned CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        op_t              op;
        logic             a_lsb;
        logic             b_msb;
    } seq_st_t;

    seq_st_t st_q, st_d;

    logic             first, last;
    logic             a_out, b_out;
    logic [WIDTH-1:0] a_val, b_val;
    logic             fast_eff, inc_eff, pre_sum;
    logic             lin_a, rin_a, lin_b, rin_b;
    shift_e           sh_dec;

    always_comb begin
        if (op_shl_i && !op_shr_i)      sh_dec = SH_LEFT;
        else if (op_shr_i && !op_shl_i) sh_dec = SH_RIGHT;
        else                            sh_dec = SH_NONE;

        st_d = st_q;
        if (start_i && !st_q.busy) begin
            st_d.busy      = 1'b1;
            st_d.cnt       = '0;
            st_d.op.sel_b  = op_selb_i;
            st_d.op.clr    = op_clr_i;
            st_d.op.sub    = op_sub_i;
            st_d.op.inc    = op_inc_i;
            st_d.op.shift  = sh_dec;
            st_d.a_lsb     = a_val[0];
            st_d.b_msb     = b_val[WIDTH-1];
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first = st_q.busy && (st_q.cnt == '0);
    assign last  = st_q.busy && (st_q.cnt == LAST_CNT);

    // fast register 3 is accumulator B itself
    assign fast_eff = (fast_addr_i == FADDR_W'(B_ADDR)) ? b_out : fast_bit_i;
    assign inc_eff  = st_q.op.inc & st_q.op.sel_b;

    dacc_serial_add i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (st_q.busy),
        .first_i (first),
        .cin_i   (inc_eff),
        .a_i     (drum_bit_i),
        .b_i     (fast_eff),
        .sum_o   (pre_sum)
    );

    // coupling across the two halves
    assign lin_a = st_q.op.clr ? 1'b0 : st_q.b_msb;
    assign rin_a = a_out;
    assign lin_b = 1'b0;
    assign rin_b = st_q.a_lsb;

    dacc_lane #(.WIDTH(WIDTH)) i_lane_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (st_q.busy),
        .first_i (first),
        .last_i  (last),
        .shift_i (st_q.op.shift),
        .clr_i   (st_q.op.clr & ~st_q.op.sel_b),
        .add_i   (~st_q.op.sel_b),
        .sub_i   (st_q.op.sub),
        .pre_i   (pre_sum),
        .lin_i   (lin_a),
        .rin_i   (rin_a),
        .out_o   (a_out),
        .val_o   (a_val)
    );

    dacc_lane #(.WIDTH(WIDTH)) i_lane_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (st_q.busy),
        .first_i (first),
        .last_i  (last),
        .shift_i (st_q.op.shift),
        .clr_i   (st_q.op.clr & st_q.op.sel_b),
        .add_i   (st_q.op.sel_b),
        .sub_i   (st_q.op.sub),
        .pre_i   (pre_sum),
        .lin_i   (lin_b),
        .rin_i   (rin_b),
        .out_o   (b_out),
        .val_o   (b_val)
    );

    assign busy_o      = st_q.busy;
    assign store_bit_o = st_q.busy & (st_q.op.sel_b ? b_out : a_out);
    assign acc_a_o     = a_val;
    assign acc_b_o     = b_val;
endmodule

// File: rtl/dacc_chk.sv
module dacc_chk #(
    parameter int unsigned WIDTH = 33
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             op_selb_i,
    input logic             op_shl_i,
    input logic             op_shr_i,
    input logic             busy_o,
    input logic [WIDTH-1:0] acc_a_o,
    input logic [WIDTH-1:0] acc_b_o
);
    localparam int unsigned RC_W = $clog2(WIDTH + 1);

    logic [RC_W-1:0]  run_cnt;
    logic [WIDTH-1:0] saved_a, saved_b;
    logic             saved_selb, saved_plain, saved_both;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt     <= '0;
            saved_a     <= '0;
            saved_b     <= '0;
            saved_selb  <= 1'b0;
            saved_plain <= 1'b0;
            saved_both  <= 1'b0;
        end else if (start_i && !busy_o) begin
            run_cnt     <= '0;
            saved_a     <= acc_a_o;
            saved_b     <= acc_b_o;
            saved_selb  <= op_selb_i;
            saved_plain <= (op_shl_i == op_shr_i);
            saved_both  <= op_shl_i & op_shr_i;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_busy_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_word_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_cnt == RC_W'(WIDTH)));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(acc_a_o) && $stable(acc_b_o)));

    assert_a_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && saved_plain && saved_selb) |-> (acc_a_o == saved_a));

    assert_b_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && saved_plain && !saved_selb) |-> (acc_b_o == saved_b));

    assert_no_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && saved_both) |->
            (saved_selb ? (acc_a_o == saved_a) : (acc_b_o == saved_b)));
endmodule

bind dacc_unit dacc_chk #(.WIDTH(WIDTH)) i_dacc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_selb_i (op_selb_i),
    .op_shl_i  (op_shl_i),
    .op_shr_i  (op_shr_i),
    .busy_o    (busy_o),
    .acc_a_o   (acc_a_o),
    .acc_b_o   (acc_b_o)
);

// File: tb/test_dacc_unit.sv
`timescale 1ns/1ps
module test_dacc_unit;
    localparam int W  = 33;
    localparam int FW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_selb_i = 1'b0, op_clr_i = 1'b0, op_sub_i = 1'b0;
    logic          op_inc_i = 1'b0, op_shl_i = 1'b0, op_shr_i = 1'b0;
    logic [FW-1:0] fast_addr_i = '0;
    logic          drum_bit_i = 1'b0, fast_bit_i = 1'b0;
    logic          busy_o, store_bit_o;
    logic [W-1:0]  acc_a_o, acc_b_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [W-1:0] exp_a = '0, exp_b = '0;

    always #2 clk = ~clk;

    dacc_unit #(.WIDTH(W), .FADDR_W(FW), .B_ADDR(3)) i_dacc_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .op_selb_i(op_selb_i), .op_clr_i(op_clr_i), .op_sub_i(op_sub_i),
        .op_inc_i(op_inc_i), .op_shl_i(op_shl_i), .op_shr_i(op_shr_i),
        .fast_addr_i(fast_addr_i), .drum_bit_i(drum_bit_i), .fast_bit_i(fast_bit_i),
        .busy_o(busy_o), .store_bit_o(store_bit_o),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one word time; expected result from the requirement arithmetic
    task automatic run_word(input string tag, input bit selb, input bit clr, input bit sub,
                            input bit inc, input bit shl, input bit shr, input int addr,
                            input logic [W-1:0] drum, input logic [W-1:0] fast, input bit mid_start);
        logic [W-1:0] sa, sb, pre, fe, base, oldsel, got_store;
        int busy_cnt;
        fe  = (addr == 3) ? exp_b : fast;
        pre = drum + fe + ((inc && selb) ? 1 : 0);
        sa = exp_a; sb = exp_b;
        if (shl && !shr) begin
            sa = {exp_a[W-2:0], clr ? 1'b0 : exp_b[W-1]};
            sb = {exp_b[W-2:0], 1'b0};
        end else if (shr && !shl) begin
            sa = {exp_a[W-1], exp_a[W-1:1]};
            sb = {exp_a[0], exp_b[W-1:1]};
        end
        oldsel = selb ? exp_b : exp_a;
        base = clr ? '0 : (selb ? sb : sa);
        if (selb) begin exp_a = sa; exp_b = sub ? base - pre : base + pre; end
        else      begin exp_b = sb; exp_a = sub ? base - pre : base + pre; end

        @(negedge clk);
        op_selb_i = selb; op_clr_i = clr; op_sub_i = sub; op_inc_i = inc;
        op_shl_i = shl; op_shr_i = shr; fast_addr_i = FW'(addr); start_i = 1'b1;
        @(posedge clk);
        busy_cnt = 0;
        got_store = '0;
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            start_i = mid_start && (k == 5);
            if (mid_start && k == 5) begin
                op_selb_i = ~selb; op_clr_i = 1'b1; op_shl_i = 1'b1; op_shr_i = 1'b0;
            end
            drum_bit_i = drum[k];
            fast_bit_i = (addr == 3) ? 1'b1 : fast[k];
            #1;
            if (busy_o) busy_cnt++;
            got_store[k] = store_bit_o;
            @(posedge clk);
        end
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check({tag, " R12 busy cycles"}, W'(busy_cnt), W'(W));
        check({tag, " R12 busy low after word"}, W'(busy_o), '0);
        check({tag, " R12 store stream"}, got_store, oldsel);
        check({tag, " acc A"}, acc_a_o, exp_a);
        check({tag, " acc B"}, acc_b_o, exp_b);
    endtask

    task automatic t_reset_R1();
        check("R1 acc A", acc_a_o, '0);
        check("R1 acc B", acc_b_o, '0);
        check("R1 busy", W'(busy_o), '0);
    endtask

    task automatic t_load_R4();
        run_word("R4 load A", 0,1,0,0,0,0, 0, 33'h0_1234_5678, 33'h0_0000_1111, 0);
        run_word("R4 load B", 1,1,0,0,0,0, 0, 33'h1_8000_0001, 33'h0_0F0F_0F0F, 0);
    endtask

    task automatic t_add_R2();
        run_word("R2 add A", 0,0,0,0,0,0, 1, 33'h0_0000_0005, 33'h1_FFFF_FFF0, 0);
        run_word("R2 add A wrap", 0,0,0,0,0,0, 1, 33'h1_FFFF_FFFF, 33'h1_FFFF_FFFF, 0);
    endtask

    task automatic t_selb_R3();
        run_word("R3 add B", 1,0,0,0,0,0, 2, 33'h0_0000_0100, 33'h0_0000_0023, 0);
    endtask

    task automatic t_sub_R5();
        run_word("R5 sub A", 0,0,1,0,0,0, 0, 33'h0_0000_0010, 33'h0_0000_0001, 0);
        run_word("R5 sub B to neg", 1,1,1,0,0,0, 0, 33'h0_0000_0007, 33'h0_0000_0000, 0);
    endtask

    task automatic t_inc_R6();
        run_word("R6 inc ignored on A", 0,1,0,1,0,0, 0, 33'h0_0000_0040, 33'h0_0000_0002, 0);
        run_word("R6 clear B to minus one", 1,1,1,1,0,0, 0, '0, '0, 0);
        run_word("R6 inc on B", 1,0,0,1,0,0, 0, '0, '0, 0);
    endtask

    task automatic t_shl_R7();
        run_word("R7 setup A", 0,1,0,0,0,0, 0, 33'h0_5555_0001, '0, 0);
        run_word("R7 setup B", 1,1,0,0,0,0, 0, 33'h1_0000_0003, '0, 0);
        run_word("R7 shift left", 0,0,0,0,1,0, 0, 33'h0_0000_0010, '0, 0);
    endtask

    task automatic t_shr_R8();
        run_word("R8 setup A neg odd", 0,1,0,0,0,0, 0, 33'h1_0000_0011, '0, 0);
        run_word("R8 shift right", 1,0,0,0,0,1, 0, '0, 33'h0_0000_0002, 0);
    endtask

    task automatic t_clr_shl_R9();
        run_word("R9 setup B msb", 1,1,0,0,0,0, 0, 33'h1_2345_0000, '0, 0);
        run_word("R9 clear blocks B to A", 1,1,1,1,1,0, 0, '0, '0, 0);
    endtask

    task automatic t_both_R10();
        run_word("R10 both shift bits", 0,0,0,0,1,1, 0, 33'h0_0000_0001, '0, 0);
    endtask

    task automatic t_fast3_R11();
        run_word("R11 A plus B via addr 3", 0,0,0,0,0,0, 3, 33'h0_0000_0003, '0, 0);
        run_word("R11 B doubled via addr 3", 1,1,0,0,0,0, 3, exp_b, '0, 0);
    endtask

    task automatic t_midstart_R12();
        run_word("R12 start while busy ignored", 0,0,0,0,0,0, 0, 33'h0_0000_0077, 33'h0_0000_0100, 1);
        repeat (3) @(negedge clk);
        #1;
        check("R12 idle hold A", acc_a_o, exp_a);
        check("R12 idle hold B", acc_b_o, exp_b);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset_R1();
        t_load_R4();
        t_add_R2();
        t_selb_R3();
        t_sub_R5();
        t_inc_R6();
        t_shl_R7();
        t_shr_R8();
        t_clr_shl_R9();
        t_both_R10();
        t_fast3_R11();
        t_midstart_R12();
        finish_up();
    end
endmodule